// File: doc/BRIEF.md
# Memory Transaction Controller with Peripheral Decode

This block connects a 16-bit processor core to two kinds of target: a bank of eight memory-mapped peripherals and an external asynchronous SRAM that is one byte wide. When the core pulses its request line, the block latches the address, store flag, size flag and write data. It then classifies the access as a peripheral access, a RAM load or a RAM store, and runs a one-hot transaction state machine. That machine returns a single-cycle ready pulse to the core.

Peripheral accesses drive a one-hot select together with per-peripheral read and clock enables. A peripheral can stretch its access by holding its ready line low. RAM stores take three clock cycles, and the block splits them into six half-clock phases. Flops on the rising edge hold the phase pairs. Flops on the falling edge mark windows that overlap those pairs. The write strobe and the low external address bit are built only from these flops, so each strobe pulse sits inside a window where the address and data do not change. A 16-bit store writes the low byte and then the high byte. An 8-bit store writes one byte and finishes one cycle sooner.

Top module: `memxact_ctrl`

## Requirements
- R1: A request whose address has 0xFF in bits 15:8 is a peripheral access, shown by `io_sel` high in its cycles. Any other request is a RAM read when `cpu_store`=0 and a RAM write when `cpu_store`=1.
- R2: During a peripheral access, `periph_sel` is the one-hot code of address bits 7:5 (bit n for value n). `periph_oe` equals `periph_sel` for loads. For stores, `periph_ce` equals `periph_sel` in the completing cycle only. Outside peripheral accesses all three are zero.
- R3: A request is taken only when `cpu_req` is high while the block is idle. Every transaction ends with `cpu_rdy` high for exactly one cycle, and the block is idle again in the next cycle.
- R4: A peripheral access is ready in its first cycle unless the selected peripheral's `periph_rdy` bit is low. Each low cycle adds one wait cycle. The ready bits of peripherals that are not selected have no effect.
- R5: A RAM read is ready in its first cycle. In that cycle `sram_oe_n` is 0 and `cpu_rdata` carries `sram_rdata`.
- R6: A RAM write has phase pairs W12, W34 and W56 in consecutive cycles. With `cpu_word`=0 (byte) ready comes in the second cycle. With `cpu_word`=1 ready comes in the third cycle.
- R7: A byte store makes one `sram_we_n` low pulse in W2, the second half of its first cycle. It writes `cpu_wdata[7:0]` to the byte at `cpu_addr`.
- R8: A word store ignores address bit 0. Its W2 pulse writes `cpu_wdata[7:0]` with `sram_addr[0]`=0. A second pulse in W5 writes `cpu_wdata[15:8]` with `sram_addr[0]`=1.
- R9: `sram_addr`, `sram_wdata` and `sram_wdata_en`=1 are steady from the falling to the rising edge of every write pulse. Write data is driven only in write cycles. `sram_oe_n` is low only in RAM read cycles.
- R10: A synchronous reset makes the block idle, with `cpu_rdy`=0, `sram_we_n`=1, `sram_oe_n`=1, `io_sel`=0 and `periph_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request for the next transaction (address clock enable) |
| cpu_addr | input | 16 | Byte address |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_word | input | 1 | 1 = 16-bit store, 0 = 8-bit store |
| cpu_wdata | input | 16 | Store data |
| cpu_rdy | output | 1 | Transaction complete |
| cpu_rdata | output | 8 | RAM read byte |
| io_sel | output | 1 | Peripheral access in progress |
| periph_sel | output | 8 | One-hot peripheral select |
| periph_oe | output | 8 | Per-peripheral read enable |
| periph_ce | output | 8 | Per-peripheral store clock enable |
| periph_rdy | input | 8 | Per-peripheral ready, low to stall |
| sram_addr | output | 16 | SRAM byte address |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_wdata | output | 8 | SRAM write byte |
| sram_wdata_en | output | 1 | Drive enable for the write byte |
| sram_rdata | input | 8 | SRAM read byte |

## Verification
The request is latched at the rising edge, and the cycle after that edge counts as cycle one. `cpu_rdy` is due in cycle one for a RAM read or an unstalled peripheral access, in cycle 1+k after k stall cycles, in cycle two for a byte store and in cycle three for a word store. The bench counts falling edges from the latch and samples outputs only at falling edges. This keeps each sample half a cycle away from the rising edges where state changes. The second strobe pulse of a word store ends on a falling edge. For that reason, pulse counts and SRAM contents are checked one rising edge after ready, when every pulse has finished. The bench also records address and data at each strobe's falling edge and compares them at its rising edge.

// File: rtl/memx_pkg.sv
package memx_pkg;
  typedef enum logic [5:0] {
    ST_IDLE = 6'b000001,
    ST_IO   = 6'b000010,
    ST_RD   = 6'b000100,
    ST_W12  = 6'b001000,
    ST_W34  = 6'b010000,
    ST_W56  = 6'b100000
  } xact_st_t;

  localparam int B_IDLE = 0;
  localparam int B_IO   = 1;
  localparam int B_RD   = 2;
  localparam int B_W12  = 3;
  localparam int B_W34  = 4;
  localparam int B_W56  = 5;

  typedef enum logic [1:0] {
    K_IO = 2'd0,
    K_RD = 2'd1,
    K_WR = 2'd2
  } xact_kind_t;
endpackage

// File: rtl/memx_decode.sv
module memx_decode
  import memx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TAG_W    = 8,
  parameter logic [TAG_W-1:0] IO_TAG = 8'hFF,
  parameter int N_PERIPH = 8,
  parameter int SEL_LSB  = 5
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                is_store,
  output xact_kind_t          kind,
  output logic [N_PERIPH-1:0] onehot
);
  localparam int SEL_W = $clog2(N_PERIPH);

  function automatic logic f_in_io_page(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W] == IO_TAG;
  endfunction

  function automatic logic [N_PERIPH-1:0] f_onehot(logic [ADDR_W-1:0] a);
    logic [N_PERIPH-1:0] v;
    v = '0;
    for (int i = 0; i < N_PERIPH; i++)
      if (a[SEL_LSB +: SEL_W] == SEL_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  always_comb begin
    if (f_in_io_page(addr)) kind = K_IO;
    else if (is_store)      kind = K_WR;
    else                    kind = K_RD;
    onehot = f_onehot(addr);
  end
endmodule

// File: rtl/memx_fsm.sv
module memx_fsm
  import memx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  xact_kind_t kind,
  input  logic       req_word,
  input  logic       cap_word,
  input  logic       periph_ok,
  output xact_st_t   state,
  output logic       accept,
  output logic       rdy
);
  xact_st_t nxt;

  assign accept = req && (state == ST_IDLE);

  always_comb begin
    nxt = state;
    rdy = 1'b0;
    unique case (state)
      ST_IDLE: if (req) begin
        unique case (kind)
          K_IO:    nxt = ST_IO;
          K_RD:    nxt = ST_RD;
          default: nxt = ST_W12;
        endcase
      end
      ST_IO: begin
        rdy = periph_ok;
        if (periph_ok) nxt = ST_IDLE;
      end
      ST_RD: begin
        rdy = 1'b1;
        nxt = ST_IDLE;
      end
      ST_W12: nxt = ST_W34;
      ST_W34: begin
        rdy = !cap_word;
        nxt = cap_word ? ST_W56 : ST_IDLE;
      end
      ST_W56: begin
        rdy = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IO && !periph_ok) |=> (state == ST_IO));
  a_r5_read_next: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_RD) |=> rdy);
  a_r6_byte_two: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_WR && !req_word) |=> !rdy ##1 rdy);
  a_r6_word_three: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_WR && req_word) |=> !rdy ##1 !rdy ##1 rdy);
endmodule

// File: rtl/memx_wrphase.sv
module memx_wrphase (
  input  logic clk,
  input  logic rst,
  input  logic in_w12,
  input  logic in_w34,
  input  logic in_w56,
  input  logic word,
  output logic we_n,
  output logic xa0
);
  // falling-edge windows: w23_q covers W2..W3, w45_q covers W4..W5,
  // xa0_q covers W4 through the first half of the following cycle
  logic w23_q, w45_q, xa0_q;
  logic pulse_lo, pulse_hi;

  always_ff @(negedge clk) begin
    if (rst) begin
      w23_q <= 1'b0;
      w45_q <= 1'b0;
      xa0_q <= 1'b0;
    end else begin
      w23_q <= in_w12;
      w45_q <= in_w34;
      xa0_q <= word && (in_w34 || in_w56);
    end
  end

  // each product pairs a rising-edge flop with a falling-edge flop
  assign pulse_lo = in_w12 && w23_q;
  assign pulse_hi = in_w56 && w45_q;
  assign we_n     = !(pulse_lo || pulse_hi);
  assign xa0      = xa0_q;

  a_r7_first_pulse_in_w12: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> in_w12);
  a_r8_second_pulse_in_w56: assert property (@(negedge clk) disable iff (rst)
    !we_n |-> (in_w56 && word));
  a_r8_high_byte_addr: assert property (@(negedge clk) disable iff (rst)
    (in_w56 && word) |-> xa0);
endmodule

// File: rtl/memxact_ctrl.sv
module memxact_ctrl
  import memx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 8,
  parameter logic [TAG_W-1:0] IO_TAG = 8'hFF,
  parameter int N_PERIPH = 8,
  parameter int SEL_LSB  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_store,
  input  logic                cpu_word,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_rdy,
  output logic [DATA_W/2-1:0] cpu_rdata,
  output logic                io_sel,
  output logic [N_PERIPH-1:0] periph_sel,
  output logic [N_PERIPH-1:0] periph_oe,
  output logic [N_PERIPH-1:0] periph_ce,
  input  logic [N_PERIPH-1:0] periph_rdy,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_we_n,
  output logic                sram_oe_n,
  output logic [DATA_W/2-1:0] sram_wdata,
  output logic                sram_wdata_en,
  input  logic [DATA_W/2-1:0] sram_rdata
);
  localparam int BYTE_W = DATA_W / 2;

  xact_kind_t          dec_kind;
  logic [N_PERIPH-1:0] dec_sel;
  xact_st_t            state;
  logic [5:0]          st;
  logic                accept, periph_ok, xa0;

  logic [ADDR_W-1:0]   cap_addr;
  logic                cap_store, cap_word;
  logic [DATA_W-1:0]   cap_wdata;
  logic [N_PERIPH-1:0] cap_sel;

  memx_decode #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IO_TAG(IO_TAG),
    .N_PERIPH(N_PERIPH), .SEL_LSB(SEL_LSB)
  ) u_dec (
    .addr(cpu_addr), .is_store(cpu_store), .kind(dec_kind), .onehot(dec_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr  <= '0;
      cap_store <= 1'b0;
      cap_word  <= 1'b0;
      cap_wdata <= '0;
      cap_sel   <= '0;
    end else if (accept) begin
      cap_addr  <= cpu_addr;
      cap_store <= cpu_store;
      cap_word  <= cpu_word;
      cap_wdata <= cpu_wdata;
      cap_sel   <= dec_sel;
    end
  end

  assign st        = state;
  assign io_sel    = st[B_IO];
  assign periph_ok = |(periph_rdy & cap_sel);

  memx_fsm u_fsm (
    .clk(clk), .rst(rst), .req(cpu_req), .kind(dec_kind),
    .req_word(cpu_word), .cap_word(cap_word), .periph_ok(periph_ok),
    .state(state), .accept(accept), .rdy(cpu_rdy)
  );

  memx_wrphase u_wr (
    .clk(clk), .rst(rst), .in_w12(st[B_W12]), .in_w34(st[B_W34]),
    .in_w56(st[B_W56]), .word(cap_word), .we_n(sram_we_n), .xa0(xa0)
  );

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    assign periph_sel[g] = io_sel && cap_sel[g];
    assign periph_oe[g]  = periph_sel[g] && !cap_store;
    assign periph_ce[g]  = periph_sel[g] && cap_store && periph_ok;
  end

  assign sram_addr     = {cap_addr[ADDR_W-1:1], cap_word ? xa0 : cap_addr[0]};
  assign sram_wdata    = (cap_word && xa0) ? cap_wdata[DATA_W-1:BYTE_W]
                                           : cap_wdata[BYTE_W-1:0];
  assign sram_wdata_en = st[B_W12] || st[B_W34] || st[B_W56];
  assign sram_oe_n     = !st[B_RD];
  assign cpu_rdata     = st[B_RD] ? sram_rdata : '0;

  a_r2_sel_onehot_in_io: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> ($countones(periph_sel) == 1));
  a_r2_no_sel_outside_io: assert property (@(posedge clk) disable iff (rst)
    !io_sel |-> (periph_sel == '0 && periph_ce == '0 && periph_oe == '0));
  a_r3_rdy_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |=> !cpu_rdy);
  a_r9_oe_excludes_drive: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_wdata_en);
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_rdy && sram_we_n && sram_oe_n && !io_sel && periph_sel == '0));
endmodule

// File: tb/memxact_ctrl_tb_top.sv
`timescale 1ns/1ps
module memxact_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_store = 1'b0, cpu_word = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_rdy;
  logic [7:0]  cpu_rdata, periph_sel, periph_oe, periph_ce, periph_rdy;
  logic        io_sel, sram_we_n, sram_oe_n, sram_wdata_en;
  logic [15:0] sram_addr;
  logic [7:0]  sram_wdata, sram_rdata;

  int checks = 0, fails = 0;
  int stall_left = 0;
  int tgt = 0;
  int pulses = 0;
  logic [15:0] rec_addr;
  logic [7:0]  rec_data;
  logic [7:0]  mem [0:65535];
  logic [7:0]  exp_mem [0:65535];

  always #10 clk = !clk;

  memxact_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_store(cpu_store), .cpu_word(cpu_word), .cpu_wdata(cpu_wdata),
    .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .io_sel(io_sel),
    .periph_sel(periph_sel), .periph_oe(periph_oe), .periph_ce(periph_ce),
    .periph_rdy(periph_rdy), .sram_addr(sram_addr), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_wdata(sram_wdata),
    .sram_wdata_en(sram_wdata_en), .sram_rdata(sram_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // peripheral stub: only the target line stalls; all others read the opposite
  for (genvar i = 0; i < 8; i++) begin : g_prdy
    assign periph_rdy[i] = (i == tgt) ? (stall_left == 0) : (stall_left != 0);
  end
  always @(posedge clk) if (io_sel && stall_left > 0) stall_left <= stall_left - 1;

  // behavioural SRAM
  assign sram_rdata = mem[sram_addr];
  always @(negedge sram_we_n) begin
    pulses++;
    rec_addr = sram_addr;
    rec_data = sram_wdata;
  end
  always @(posedge sram_we_n) if (!rst) begin
    chk(sram_addr == rec_addr, "R9", "addr stable over pulse", sram_addr, rec_addr);
    chk(sram_wdata == rec_data, "R9", "data stable over pulse", sram_wdata, rec_data);
    chk(sram_wdata_en == 1'b1, "R9", "data driven at pulse end", sram_wdata_en, 1);
    mem[sram_addr] = sram_wdata;
  end

  function automatic int exp_cycles(bit io, bit st, bit wd, int stalls);
    if (io) return 1 + stalls;
    if (!st) return 1;
    return wd ? 3 : 2;
  endfunction

  task automatic xact(input logic [15:0] a, input bit st, input bit wd,
                      input logic [15:0] d, input int stalls);
    bit io;
    int n;
    bit got;
    logic [7:0] oh;
    io = (a[15:8] == 8'hFF);
    oh = 8'h01 << a[7:5];
    @(negedge clk);
    cpu_addr = a; cpu_store = st; cpu_word = wd; cpu_wdata = d; cpu_req = 1'b1;
    stall_left = io ? stalls : 0;
    tgt = int'(a[7:5]);
    pulses = 0;
    @(posedge clk);
    #1 cpu_req = 1'b0;
    n = 0; got = 0;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (cpu_rdy) got = 1'b1;
    end
    chk(n == exp_cycles(io, st, wd, stalls), io ? "R4" : (st ? "R6" : "R5"),
        "cycles to ready", n, exp_cycles(io, st, wd, stalls));
    chk(io_sel == io, "R1", "io_sel at ready", io_sel, io);
    if (io) begin
      chk(periph_sel == oh, "R2", "periph_sel", periph_sel, oh);
      chk(periph_oe == (st ? 8'h00 : oh), "R2", "periph_oe", periph_oe, st ? 8'h00 : oh);
      chk(periph_ce == (st ? oh : 8'h00), "R2", "periph_ce", periph_ce, st ? oh : 8'h00);
    end else begin
      chk(periph_sel == 8'h00, "R2", "no select for RAM", periph_sel, 0);
      if (!st) begin
        chk(sram_oe_n == 1'b0, "R5", "oe_n in read", sram_oe_n, 0);
        chk(cpu_rdata == exp_mem[a], "R5", "read data", cpu_rdata, exp_mem[a]);
      end else begin
        chk(sram_oe_n == 1'b1, "R9", "oe_n in write", sram_oe_n, 1);
        chk(sram_wdata_en == 1'b1, "R9", "drive in write", sram_wdata_en, 1);
      end
    end
    @(posedge clk);
    #1;
    chk(cpu_rdy == 1'b0, "R3", "ready single cycle", cpu_rdy, 0);
    chk(sram_wdata_en == 1'b0, "R9", "no drive when idle", sram_wdata_en, 0);
    if (!io && st) begin
      if (wd) begin
        exp_mem[{a[15:1], 1'b0}] = d[7:0];
        exp_mem[{a[15:1], 1'b1}] = d[15:8];
        chk(pulses == 2, "R8", "word pulse count", pulses, 2);
        chk(mem[{a[15:1], 1'b0}] == d[7:0], "R8", "low byte", mem[{a[15:1], 1'b0}], d[7:0]);
        chk(mem[{a[15:1], 1'b1}] == d[15:8], "R8", "high byte", mem[{a[15:1], 1'b1}], d[15:8]);
      end else begin
        exp_mem[a] = d[7:0];
        chk(pulses == 1, "R7", "byte pulse count", pulses, 1);
        chk(mem[a] == d[7:0], "R7", "byte written", mem[a], d[7:0]);
        chk(mem[a ^ 16'h1] == exp_mem[a ^ 16'h1], "R7", "neighbour kept",
            mem[a ^ 16'h1], exp_mem[a ^ 16'h1]);
      end
    end else begin
      chk(pulses == 0, io ? "R1" : "R5", "no write pulse", pulses, 0);
    end
  endtask

  initial begin : watchdog
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 65536; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_rdy == 0 && sram_we_n == 1 && sram_oe_n == 1 && io_sel == 0
        && periph_sel == 0, "R10", "reset outputs",
        {cpu_rdy, sram_we_n, sram_oe_n, io_sel}, 4'b0110);
    rst = 1'b0;
    // R1/R3: request held low must not start anything
    repeat (2) @(negedge clk);
    chk(cpu_rdy == 0 && io_sel == 0 && sram_oe_n == 1, "R3", "no request idle",
        cpu_rdy, 0);
    // directed corners
    xact(16'hFEFF, 1, 0, 16'h00A5, 0);   // R1: just below I/O page is RAM
    xact(16'hFEFF, 0, 0, 16'h0000, 0);
    xact(16'hFF00, 0, 0, 16'h0000, 0);   // R2: peripheral 0, load
    xact(16'hFFE0, 1, 0, 16'h1234, 0);   // R2: peripheral 7, store
    xact(16'hFF40, 0, 0, 16'h0000, 3);   // R4: three stalls
    xact(16'hFFA0, 1, 0, 16'h0000, 1);   // R4: one stall on a store
    xact(16'h1201, 1, 1, 16'hBEEF, 0);   // R8: odd address ignored
    xact(16'h1200, 0, 0, 16'h0000, 0);
    xact(16'h1201, 0, 0, 16'h0000, 0);
    xact(16'h1203, 1, 0, 16'h0077, 0);   // R7: odd byte
    xact(16'h1203, 0, 0, 16'h0000, 0);
    // random mix
    for (int k = 0; k < 150; k++) begin
      int kind;
      logic [15:0] a;
      kind = int'($urandom_range(0, 3));
      a = 16'h1200 | 16'($urandom_range(0, 31));
      if (kind == 0)
        xact({8'hFF, 8'($urandom)}, bit'($urandom_range(0, 1)), 0, 16'($urandom),
             int'($urandom_range(0, 4)));
      else if (kind == 1) xact(a, 0, 0, 16'h0, 0);
      else xact(a, 1, bit'($urandom_range(0, 1)), 16'($urandom), 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule